// File: doc/BRIEF.md
# Instrument Status Byte and Service-Request Logic

This block builds the eight-bit status byte of a test instrument from summary signals that lower status registers produce. Five inputs fill fixed positions: an error-queue-occupied flag, a questionable-register summary, a message-available flag, an operation-register summary, and a fifth bit that the block reduces itself from a standard-event vector and its enable mask. Bits 0 and 1 are unused and read as zero.

A host-programmable request mask selects which status bits may ask for service. Bit 6 of the byte is never stored. It is the OR of every other status bit ANDed with its mask bit, and the mask's own bit 6 has no effect anywhere. A sticky request output is set when an enabled status bit goes from low to high, and a serial-poll strobe clears it. A bit that stays high does not raise the request again.

Top module: `stb_srq_ctrl`

## Requirements
- R1: `status_byte[2]` equals `errq_nonempty` in the same cycle.
- R2: `status_byte[3]` follows `quest_sum`, `status_byte[4]` follows `msg_avail` and `status_byte[7]` follows `oper_sum`, all combinationally.
- R3: `status_byte[5]` is 1 exactly when some bit of `evt_status` is 1 and the same bit of `evt_enable` is 1.
- R4: `status_byte[1:0]` always reads 2'b00.
- R5: `status_byte[6]` is 1 exactly when some bit of `status_byte` other than bit 6 is 1 together with the same bit of the request mask. Mask bit 6 affects neither `status_byte[6]` nor `srq`.
- R6: When `mask_we` is high at a rising clock edge, `mask_wdata` is stored. From then on `mask_rdata` returns the stored value with bit 6 forced to 0. Reset clears the mask to 8'h00.
- R7: `srq` becomes 1 after the clock edge at which some status bit ANDed with its mask bit is 1, when the same masked bit was 0 at the previous edge. Enabling the mask on a bit that is already high counts as such a rise.
- R8: A masked bit that stays high, or a status bit whose mask bit is 0, never sets `srq`.
- R9: `srq` is cleared by the clock edge at which `poll_strobe` is high. If a qualifying rise occurs at that same edge, `srq` stays set.
- R10: While `rst_n` is low, `srq` is 0 and the record of previous masked bits is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| errq_nonempty | input | 1 | Error queue holds at least one entry |
| quest_sum | input | 1 | Questionable-register summary |
| msg_avail | input | 1 | Output message ready to be read |
| evt_status | input | EVT_W | Standard-event register bits |
| evt_enable | input | EVT_W | Standard-event enable mask |
| oper_sum | input | 1 | Operation-register summary |
| mask_we | input | 1 | Request-mask write strobe |
| mask_wdata | input | 8 | Request-mask write value |
| mask_rdata | output | 8 | Request-mask readback, bit 6 always 0 |
| status_byte | output | 8 | Assembled status byte |
| poll_strobe | input | 1 | Serial-poll strobe that clears the request |
| srq | output | 1 | Sticky service-request flag |

## Verification
The bench sets the mask bit of a status bit and holds that bit high across several polls. A design that triggers on level instead of on the edge would raise the request again after each poll. It sets only mask bit 6 while a real status bit is high. A design that did not ignore mask bit 6 would set the summary bit or the request. It asserts the poll strobe at the same edge as a fresh enabled rise, which catches a design where clear takes priority. It also enables the mask on a bit that is already high, which a design that registers raw status bits instead of masked bits would miss.

// File: rtl/stb_pkg.sv
package stb_pkg;
  localparam int STB_W     = 8;
  localparam int POS_ERRQ  = 2;
  localparam int POS_QUEST = 3;
  localparam int POS_MSG   = 4;
  localparam int POS_EVT   = 5;
  localparam int POS_MSS   = 6;
  localparam int POS_OPER  = 7;
  // Mask bits that can take part in a request: every bit except the summary
  localparam logic [STB_W-1:0] REQ_ELIGIBLE = ~(STB_W'(1) << POS_MSS);

  // Status byte without the summary bit, placed by position
  function automatic logic [STB_W-1:0] place_bits(
    input logic errq, input logic quest, input logic msg,
    input logic evt,  input logic oper);
    logic [STB_W-1:0] b;
    b = '0;
    b[POS_ERRQ]  = errq;
    b[POS_QUEST] = quest;
    b[POS_MSG]   = msg;
    b[POS_EVT]   = evt;
    b[POS_OPER]  = oper;
    return b;
  endfunction
endpackage

// File: rtl/stb_masked_any.sv
module stb_masked_any #(
  parameter int W = 8
) (
  input  logic [W-1:0] bits,
  input  logic [W-1:0] enables,
  output logic         any
);
  assign any = |(bits & enables);
endmodule

// File: rtl/stb_rise_detect.sv
module stb_rise_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] masked,
  output logic [W-1:0] rise,
  output logic         rise_any
);
  logic [W-1:0] prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= masked[i];
    end
    assign rise[i] = masked[i] & ~prev_q[i];
  end

  assign rise_any = |rise;

  // R10
  prev_clear_chk: assert property (@(posedge clk) !rst_n |-> prev_q == '0);
endmodule

// File: rtl/stb_srq_flag.sv
module stb_srq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr_evt) flag <= 1'b0;
  end

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_evt && !clr_evt) |=> $stable(flag));
endmodule

// File: rtl/stb_srq_ctrl.sv
module stb_srq_ctrl
  import stb_pkg::*;
#(
  parameter int EVT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             errq_nonempty,
  input  logic             quest_sum,
  input  logic             msg_avail,
  input  logic [EVT_W-1:0] evt_status,
  input  logic [EVT_W-1:0] evt_enable,
  input  logic             oper_sum,
  input  logic             mask_we,
  input  logic [STB_W-1:0] mask_wdata,
  output logic [STB_W-1:0] mask_rdata,
  output logic [STB_W-1:0] status_byte,
  input  logic             poll_strobe,
  output logic             srq
);
  logic             evt_summary;
  logic             mss;
  logic [STB_W-1:0] mask_q;
  logic [STB_W-1:0] base_bits;
  logic [STB_W-1:0] eff_mask;
  logic [STB_W-1:0] masked_bits;
  logic [STB_W-1:0] rise_vec;
  logic             rise_any;

  stb_masked_any #(.W(EVT_W)) u_evt_sum (
    .bits(evt_status), .enables(evt_enable), .any(evt_summary));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_wdata & REQ_ELIGIBLE;
  end

  assign eff_mask    = mask_q & REQ_ELIGIBLE;
  assign mask_rdata  = eff_mask;
  assign base_bits   = place_bits(errq_nonempty, quest_sum, msg_avail,
                                  evt_summary, oper_sum);
  assign masked_bits = base_bits & eff_mask;

  stb_masked_any #(.W(STB_W)) u_mss (
    .bits(base_bits), .enables(eff_mask), .any(mss));

  always_comb begin
    status_byte          = base_bits;
    status_byte[POS_MSS] = mss;
  end

  stb_rise_detect #(.W(STB_W)) u_rise (
    .clk(clk), .rst_n(rst_n), .masked(masked_bits),
    .rise(rise_vec), .rise_any(rise_any));

  stb_srq_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_evt(rise_any),
    .clr_evt(poll_strobe), .flag(srq));

  // R6
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> mask_rdata == ($past(mask_wdata) & 8'hBF));
  // R7
  srq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srq) |-> $past(rise_any));
  // R9
  poll_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_strobe && !rise_any) |=> !srq);
  // R5
  mss_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[POS_MSS] == |(status_byte & mask_rdata & 8'hBF));
endmodule

// File: tb/tb_stb_srq_ctrl.sv
module tb_stb_srq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       errq_nonempty = 1'b0, quest_sum = 1'b0, msg_avail = 1'b0, oper_sum = 1'b0;
  logic [7:0] evt_status = '0, evt_enable = '0;
  logic       mask_we = 1'b0;
  logic [7:0] mask_wdata = '0;
  logic [7:0] mask_rdata, status_byte;
  logic       poll_strobe = 1'b0;
  logic       srq;
  int         n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  stb_srq_ctrl #(.EVT_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .errq_nonempty(errq_nonempty), .quest_sum(quest_sum),
    .msg_avail(msg_avail), .evt_status(evt_status), .evt_enable(evt_enable),
    .oper_sum(oper_sum), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .mask_rdata(mask_rdata), .status_byte(status_byte),
    .poll_strobe(poll_strobe), .srq(srq));

  // {errq,quest,msg,oper}, evt_status, evt_enable, mask, expected status byte
  localparam logic [35:0] VEC [7] = '{
    36'h0_00_00_00_00, 36'h8_00_00_00_04, 36'h8_00_00_04_44,
    36'h6_0F_F0_20_18, 36'h0_10_10_20_60, 36'h1_00_00_40_80,
    36'hF_FF_01_80_FC };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_mask(input logic [7:0] m);
    mask_we = 1'b1; mask_wdata = m;
    tick();
    mask_we = 1'b0;
  endtask

  task automatic poll();
    poll_strobe = 1'b1;
    tick();
    poll_strobe = 1'b0;
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R10 srq in reset", {7'd0, srq}, 8'h00);
    chk("R6 mask reset", mask_rdata, 8'h00);
    chk("R4 idle byte", status_byte, 8'h00);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < 7; i++) begin
      {errq_nonempty, quest_sum, msg_avail, oper_sum} = VEC[i][35:32];
      evt_status = VEC[i][31:24];
      evt_enable = VEC[i][23:16];
      wr_mask(VEC[i][15:8]);
      #1;
      chk("R1-R5 vector byte R1 R2 R3 R4 R5", status_byte, VEC[i][7:0]);
      chk("R6 vector mask", mask_rdata, VEC[i][15:8] & 8'hBF);
    end

    wr_mask(8'hFF);
    chk("R6 bit6 readback", mask_rdata, 8'hBF);

    // Quiet state, request enabled only on message bit
    {errq_nonempty, quest_sum, msg_avail, oper_sum} = 4'h0;
    evt_status = '0; evt_enable = '0;
    wr_mask(8'h10);
    poll();
    chk("R9 poll clears", {7'd0, srq}, 8'h00);
    msg_avail = 1'b1;
    tick();
    chk("R7 rise sets", {7'd0, srq}, 8'h01);
    poll();
    chk("R9 poll clears held", {7'd0, srq}, 8'h00);
    tick(); tick(); tick();
    chk("R8 held level no refire", {7'd0, srq}, 8'h00);
    msg_avail = 1'b0; tick();
    msg_avail = 1'b1; tick();
    chk("R7 second rise", {7'd0, srq}, 8'h01);
    poll();
    msg_avail = 1'b0;
    errq_nonempty = 1'b1;
    tick(); tick();
    chk("R8 disabled bit ignored", {7'd0, srq}, 8'h00);
    errq_nonempty = 1'b0;

    wr_mask(8'h40);
    oper_sum = 1'b1;
    tick(); tick();
    chk("R5 mask bit6 no srq", {7'd0, srq}, 8'h00);
    chk("R5 mask bit6 no summary", status_byte, 8'h80);

    // Enabling a bit already high: rise seen at the edge after the write
    wr_mask(8'h80);
    poll_strobe = 1'b1;
    tick();
    poll_strobe = 1'b0;
    chk("R9 set wins over poll R7", {7'd0, srq}, 8'h01);
    poll();
    chk("R9 cleared after", {7'd0, srq}, 8'h00);

    oper_sum = 1'b0; tick();
    oper_sum = 1'b1; tick();
    chk("R7 before reset", {7'd0, srq}, 8'h01);
    rst_n = 1'b0;
    #1;
    chk("R10 reset clears srq", {7'd0, srq}, 8'h00);
    chk("R6 reset clears mask", mask_rdata, 8'h00);
    tick();
    rst_n = 1'b1;
    tick(); tick();
    chk("R10 no srq after reset with mask zero", {7'd0, srq}, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule